// File: doc/BRIEF.md
# RGB Panel Video Timing Generator

This block drives the timing side of a parallel RGB panel. From a source clock it derives a pixel strobe. It then walks every line through four segments, measured in pixels, and every frame through the same four segments, measured in lines. From this walk it produces horizontal sync, vertical sync, data-enable, a pixel-clock output and the coordinates of the current active pixel. Pixel data, blending and memory fetch belong to other blocks, which follow `de_o`, `px_x` and `px_y`.

Software programs the block through a small register port. Every segment length and both active sizes are written as the count minus one. The pixel divider is also written minus one, so the 8-bit field selects ratios from 1 to 256. A frame interrupt can be enabled. It is raised when the frame enters its vertical front porch, stays set, and is cleared by writing a one to it.

Each segment walker is a four-state machine. In the reset and disabled condition it holds in `SEG_SYNC` with count zero. While video runs it steps `SEG_SYNC -> SEG_BACK -> SEG_ACTIVE -> SEG_FRONT -> SEG_SYNC`, taking each transition when the count reaches the programmed length of the segment it is in. The horizontal walker steps on the pixel strobe. The vertical walker steps when the horizontal walker wraps from `SEG_FRONT` back to `SEG_SYNC`.

Register map (`reg_addr`):
- 0, control: bit0 video on, bit1 invert hsync, bit2 invert vsync, bit3 invert data-enable, bit4 invert pixel clock, bit5 frame interrupt enable, bits 15:8 divider minus one.
- 1, horizontal: bits 7:0 sync width-1, bits 15:8 back porch-1, bits 23:16 front porch-1.
- 2, vertical: the same layout as register 1, counted in lines.
- 3, active: bits 15:0 width-1, bits 31:16 height-1.
- 4, status: bit0 frame interrupt pending, cleared by writing 1.

`reg_rdata` returns the register selected by `reg_addr` combinationally. The parameters must satisfy PW ≤ 8, AW ≤ 16 and AW ≥ PW.

Top module: `rvt_timing_gen`

## Requirements
- R1: After reset every output is at its inactive level: hsync, vsync, data-enable, pixel strobe and interrupt are 0, and the status read returns 0.
- R2: With video on, each line is hsync asserted for (sync field+1) pixels, then back porch (field+1), then active (width field+1), then front porch (field+1), repeating.
- R3: Frames follow the same order counted in lines (vsync, back porch, active, front porch), and a line boundary advances the frame by one line.
- R4: Data-enable is asserted only when both walkers are in their active segments. `px_x` and `px_y` count from 0 inside the active area and are 0 outside it.
- R5: `pclk_en_o` pulses for one source cycle in every (divider field+1) cycles. Field values 0 to 255 give ratios 1 to 256, and all timing advances only on the strobe.
- R6: Control bits 1 to 4 each invert one output (hsync, vsync, data-enable, `pclk_o`) independently.
- R7: With bit5 set, status bit0 becomes 1 on the first pixel of the vertical front porch and stays 1 until it is cleared.
- R8: With bit5 clear, status bit0 is never set.
- R9: Writing 1 to status bit0 clears it. Writing 0 leaves it unchanged.
- R10: Writes to the horizontal, vertical and active registers during a running frame do not alter that frame; they are applied at the next frame start.
- R11: With video off, hsync, vsync and data-enable sit at their inactive (polarity-adjusted) levels and `pclk_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data-enable, polarity applied |
| pclk_en_o | output | 1 | One-cycle pixel strobe |
| pclk_o | output | 1 | Pixel strobe with polarity applied |
| px_x | output | AW | Active pixel column |
| px_y | output | AW | Active pixel row |
| irq_o | output | 1 | Frame interrupt pending |

## Verification
The assertions assume that register writes arrive as single-cycle strobes. They also assume that a status clear that coincides with a front-porch entry loses to the set; the bench keeps clears to periods when video is off, so that no entry can happen then. The shadow-hold property relies on the timing registers changing only through the write port. The stimulus reprograms the timing only while video is off, except for one deliberate write in the middle of a frame. The frame comparisons depend on the bench starting every run from the disabled state, so each enabling write is preceded by a write that turns video off.

// File: rtl/rvt_pkg.sv
package rvt_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC   = 2'd0,
        SEG_BACK   = 2'd1,
        SEG_ACTIVE = 2'd2,
        SEG_FRONT  = 2'd3
    } seg_e;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_HOR  = 3'd1;
    localparam logic [2:0] ADDR_VER  = 3'd2;
    localparam logic [2:0] ADDR_ACT  = 3'd3;
    localparam logic [2:0] ADDR_STAT = 3'd4;

    localparam int FLAG_BITS   = 6;
    localparam int F_EN        = 0;
    localparam int F_INV_HS    = 1;
    localparam int F_INV_VS    = 2;
    localparam int F_INV_DE    = 3;
    localparam int F_INV_PCLK  = 4;
    localparam int F_IRQ_EN    = 5;
    localparam int DIV_LSB     = 8;
    localparam int FIELD_STEP  = 8;
    localparam int HEIGHT_LSB  = 16;
endpackage

// File: rtl/rvt_pclk_div.sv
module rvt_pclk_div #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!run)     cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rvt_seg_fsm.sv
module rvt_seg_fsm
    import rvt_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [CW-1:0] len_sync,
    input  logic [CW-1:0] len_back,
    input  logic [CW-1:0] len_act,
    input  logic [CW-1:0] len_front,
    output seg_e          seg,
    output logic [CW-1:0] cnt,
    output logic          seg_done,
    output logic          wrap
);
    seg_e          seg_q, seg_nx;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cur_len;

    always_comb begin
        unique case (seg_q)
            SEG_SYNC:   begin cur_len = len_sync;  seg_nx = SEG_BACK;   end
            SEG_BACK:   begin cur_len = len_back;  seg_nx = SEG_ACTIVE; end
            SEG_ACTIVE: begin cur_len = len_act;   seg_nx = SEG_FRONT;  end
            SEG_FRONT:  begin cur_len = len_front; seg_nx = SEG_SYNC;   end
            default:    begin cur_len = len_sync;  seg_nx = SEG_SYNC;   end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= SEG_SYNC;
            cnt_q <= '0;
        end else if (!run) begin
            seg_q <= SEG_SYNC;
            cnt_q <= '0;
        end else if (step) begin
            if (cnt_q == cur_len) begin
                seg_q <= seg_nx;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign seg      = seg_q;
    assign cnt      = cnt_q;
    assign seg_done = run && step && (cnt_q == cur_len);
    assign wrap     = seg_done && (seg_q == SEG_FRONT);
endmodule

// File: rtl/rvt_regs.sv
module rvt_regs
    import rvt_pkg::*;
#(
    parameter int PW = 8,
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 frame_evt,
    output logic [FLAG_BITS-1:0] flags,
    output logic [DW-1:0]        div,
    output logic [3*PW-1:0]      hor,
    output logic [3*PW-1:0]      ver,
    output logic [2*AW-1:0]      act,
    output logic                 irq
);
    logic wr_ctrl, wr_hor, wr_ver, wr_act, clr_irq, set_irq;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_hor  = reg_wr && (reg_addr == ADDR_HOR);
    assign wr_ver  = reg_wr && (reg_addr == ADDR_VER);
    assign wr_act  = reg_wr && (reg_addr == ADDR_ACT);
    assign clr_irq = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];
    assign set_irq = frame_evt && flags[F_IRQ_EN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            div   <= '0;
            hor   <= '0;
            ver   <= '0;
            act   <= '0;
            irq   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                flags <= reg_wdata[FLAG_BITS-1:0];
                div   <= reg_wdata[DIV_LSB +: DW];
            end
            if (wr_hor)
                hor <= {reg_wdata[2*FIELD_STEP +: PW], reg_wdata[FIELD_STEP +: PW], reg_wdata[0 +: PW]};
            if (wr_ver)
                ver <= {reg_wdata[2*FIELD_STEP +: PW], reg_wdata[FIELD_STEP +: PW], reg_wdata[0 +: PW]};
            if (wr_act)
                act <= {reg_wdata[HEIGHT_LSB +: AW], reg_wdata[0 +: AW]};
            if (set_irq)      irq <= 1'b1;
            else if (clr_irq) irq <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[FLAG_BITS-1:0]  = flags;
                reg_rdata[DIV_LSB +: DW]  = div;
            end
            ADDR_HOR: begin
                reg_rdata[0 +: PW]              = hor[0 +: PW];
                reg_rdata[FIELD_STEP +: PW]     = hor[PW +: PW];
                reg_rdata[2*FIELD_STEP +: PW]   = hor[2*PW +: PW];
            end
            ADDR_VER: begin
                reg_rdata[0 +: PW]              = ver[0 +: PW];
                reg_rdata[FIELD_STEP +: PW]     = ver[PW +: PW];
                reg_rdata[2*FIELD_STEP +: PW]   = ver[2*PW +: PW];
            end
            ADDR_ACT: begin
                reg_rdata[0 +: AW]          = act[0 +: AW];
                reg_rdata[HEIGHT_LSB +: AW] = act[AW +: AW];
            end
            ADDR_STAT: reg_rdata[0] = irq;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rvt_timing_gen.sv
module rvt_timing_gen
    import rvt_pkg::*;
#(
    parameter int PW = 8,
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          pclk_en_o,
    output logic          pclk_o,
    output logic [AW-1:0] px_x,
    output logic [AW-1:0] px_y,
    output logic          irq_o
);
    logic [FLAG_BITS-1:0] flags;
    logic [DW-1:0]        div;
    logic [3*PW-1:0]      hor, ver, sh_hor, sh_ver;
    logic [2*AW-1:0]      act, sh_act;
    logic                 run, inv_hs, inv_vs, inv_de, inv_pclk, irq_en;
    logic                 tick, frame_evt, frame_end;
    seg_e                 h_seg, v_seg;
    logic [AW-1:0]        h_cnt, v_cnt;
    logic                 h_done, h_wrap, v_done;

    assign run      = flags[F_EN];
    assign inv_hs   = flags[F_INV_HS];
    assign inv_vs   = flags[F_INV_VS];
    assign inv_de   = flags[F_INV_DE];
    assign inv_pclk = flags[F_INV_PCLK];
    assign irq_en   = flags[F_IRQ_EN];

    rvt_regs #(.PW(PW), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_evt(frame_evt),
        .flags(flags), .div(div), .hor(hor), .ver(ver), .act(act), .irq(irq_o)
    );

    rvt_pclk_div #(.DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div), .tick(tick)
    );

    // timing fields are copied while idle and at each frame boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_hor <= '0;
            sh_ver <= '0;
            sh_act <= '0;
        end else if (!run || frame_end) begin
            sh_hor <= hor;
            sh_ver <= ver;
            sh_act <= act;
        end
    end

    rvt_seg_fsm #(.CW(AW)) u_hfsm (
        .clk(clk), .rst_n(rst_n), .run(run), .step(tick),
        .len_sync(AW'(sh_hor[0 +: PW])), .len_back(AW'(sh_hor[PW +: PW])),
        .len_act(sh_act[0 +: AW]), .len_front(AW'(sh_hor[2*PW +: PW])),
        .seg(h_seg), .cnt(h_cnt), .seg_done(h_done), .wrap(h_wrap)
    );

    rvt_seg_fsm #(.CW(AW)) u_vfsm (
        .clk(clk), .rst_n(rst_n), .run(run), .step(h_wrap),
        .len_sync(AW'(sh_ver[0 +: PW])), .len_back(AW'(sh_ver[PW +: PW])),
        .len_act(sh_act[AW +: AW]), .len_front(AW'(sh_ver[2*PW +: PW])),
        .seg(v_seg), .cnt(v_cnt), .seg_done(v_done), .wrap(frame_end)
    );

    assign frame_evt = v_done && (v_seg == SEG_ACTIVE);

    always_comb begin
        hsync_o   = (run && (h_seg == SEG_SYNC)) ^ inv_hs;
        vsync_o   = (run && (v_seg == SEG_SYNC)) ^ inv_vs;
        de_o      = (run && (h_seg == SEG_ACTIVE) && (v_seg == SEG_ACTIVE)) ^ inv_de;
        pclk_en_o = tick;
        pclk_o    = tick ^ inv_pclk;
        px_x      = (h_seg == SEG_ACTIVE) ? h_cnt : '0;
        px_y      = (v_seg == SEG_ACTIVE) ? v_cnt : '0;
    end
endmodule

// File: rtl/rvt_timing_gen_chk.sv
module rvt_timing_gen_chk #(
    parameter int PW = 8,
    parameter int AW = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic            inv_hs,
    input logic            inv_vs,
    input logic            inv_de,
    input logic            irq_en,
    input logic            hsync_o,
    input logic            vsync_o,
    input logic            de_o,
    input logic            pclk_en_o,
    input logic [AW-1:0]   px_x,
    input logic            irq_o,
    input logic            reg_wr,
    input logic [2:0]      reg_addr,
    input logic [31:0]     reg_wdata,
    input logic            frame_evt,
    input logic            frame_end,
    input logic [3*PW-1:0] sh_hor
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (hsync_o == inv_hs && vsync_o == inv_vs && de_o == inv_de && !pclk_en_o)); // R11

    AST_DE_CLEAR_OF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (run && de_o != inv_de) |-> (hsync_o == inv_hs && vsync_o == inv_vs)); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd4 && reg_wdata[0] && !frame_evt) |=> !irq_o); // R9

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(irq_en)); // R8

    AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(frame_end)) |-> $stable(sh_hor)); // R10

    AST_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pclk_en_o) |=> (!run || $stable(px_x))); // R5
endmodule

bind rvt_timing_gen rvt_timing_gen_chk #(.PW(PW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .inv_hs(inv_hs), .inv_vs(inv_vs),
    .inv_de(inv_de), .irq_en(irq_en), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .pclk_en_o(pclk_en_o), .px_x(px_x), .irq_o(irq_o),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .frame_evt(frame_evt), .frame_end(frame_end), .sh_hor(sh_hor)
);

// File: tb/rvt_timing_gen_test.sv
module rvt_timing_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int NV = 4;
    // hs hb ha hf vs vb va vf div flags (flags: 2 inv hs, 4 inv vs, 8 inv de, 16 inv pclk, 32 irq en)
    localparam int VEC [NV][10] = '{
        '{1, 2, 4, 1, 1, 1, 3, 1,   0, 32},
        '{2, 1, 3, 2, 2, 1, 2, 1,   2, 62},
        '{1, 1, 2, 1, 1, 1, 1, 1, 255,  0},
        '{3, 2, 5, 1, 1, 2, 4, 2,   1, 36}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [31:0]   reg_wdata = 32'd0;
    logic [31:0]   reg_rdata;
    logic          hsync_o, vsync_o, de_o, pclk_en_o, pclk_o, irq_o;
    logic [AW-1:0] px_x, px_y;
    int            n_chk = 0;
    int            n_bad = 0;
    int            cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rvt_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .pclk_en_o(pclk_en_o), .pclk_o(pclk_o),
        .px_x(px_x), .px_y(px_y), .irq_o(irq_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_vec(input int v, input bit mid);
        int hs, hb, ha, hf, vs, vb, va, vf, d, fl, htot, vtot, ncyc;
        hs = VEC[v][0]; hb = VEC[v][1]; ha = VEC[v][2]; hf = VEC[v][3];
        vs = VEC[v][4]; vb = VEC[v][5]; va = VEC[v][6]; vf = VEC[v][7];
        d  = VEC[v][8]; fl = VEC[v][9];
        htot = hs + hb + ha + hf;
        vtot = vs + vb + va + vf;
        wr(3'd0, 32'd0);
        wr(3'd4, 32'd1);
        wr(3'd1, 32'((hs-1) | ((hb-1) << 8) | ((hf-1) << 16)));
        wr(3'd2, 32'((vs-1) | ((vb-1) << 8) | ((vf-1) << 16)));
        wr(3'd3, 32'((ha-1) | ((va-1) << 16)));
        wr(3'd0, 32'(1 | fl | (d << 8)));
        ncyc = mid ? vtot*htot*(d+1) : (vtot+1)*htot*(d+1);
        for (int j = 0; j < ncyc; j++) begin
            int p, hp, ln;
            bit tk, hs_e, vs_e, ha_e, va_e, irq_e;
            p  = j / (d+1);
            tk = (j % (d+1)) == d;
            hp = p % htot;
            ln = (p / htot) % vtot;
            hs_e = hp < hs;
            vs_e = ln < vs;
            ha_e = (hp >= hs+hb) && (hp < hs+hb+ha);
            va_e = (ln >= vs+vb) && (ln < vs+vb+va);
            irq_e = ((fl & 32) != 0) && (p >= (vs+vb+va)*htot);
            chk("R2/R6", "hsync", int'(hsync_o), int'(hs_e ^ ((fl & 2) != 0)));
            chk("R3/R6", "vsync", int'(vsync_o), int'(vs_e ^ ((fl & 4) != 0)));
            chk("R4/R6", "de", int'(de_o), int'((ha_e && va_e) ^ ((fl & 8) != 0)));
            chk("R5", "pclk_en", int'(pclk_en_o), int'(tk));
            chk("R6", "pclk", int'(pclk_o), int'(tk ^ ((fl & 16) != 0)));
            chk("R4", "px_x", int'(px_x), ha_e ? hp-hs-hb : 0);
            chk("R4", "px_y", int'(px_y), va_e ? ln-vs-vb : 0);
            chk(((fl & 32) != 0) ? "R7" : "R8", "irq", int'(irq_o), int'(irq_e));
            if (mid && j == 3*(d+1)) begin
                // R10: new horizontal timing written in mid-frame
                reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0004_0302;
            end
            if (mid && j == 3*(d+1)+1) reg_wr = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "hsync", int'(hsync_o), 0);
        chk("R1", "vsync", int'(vsync_o), 0);
        chk("R1", "de", int'(de_o), 0);
        chk("R1", "pclk_en", int'(pclk_en_o), 0);
        chk("R1", "irq", int'(irq_o), 0);
        reg_addr = 3'd4;
        #1 chk("R1", "status", int'(reg_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: video off with all inversions, outputs at inverted idle
        wr(3'd0, 32'h0000_001E);
        repeat (3) @(negedge clk);
        chk("R11", "hsync idle", int'(hsync_o), 1);
        chk("R11", "vsync idle", int'(vsync_o), 1);
        chk("R11", "de idle", int'(de_o), 1);
        chk("R11", "pclk_en idle", int'(pclk_en_o), 0);

        for (int v = 0; v < NV; v++) run_vec(v, 1'b0);

        // R10 mid-frame write keeps current frame unchanged
        run_vec(0, 1'b1);

        // R7 sticky, R9 write-1-to-clear, write-0 ignored
        run_vec(0, 1'b0);
        wr(3'd0, 32'd0);
        @(negedge clk);
        chk("R7", "irq sticky after stop", int'(irq_o), 1);
        wr(3'd4, 32'd0);
        reg_addr = 3'd4;
        #1 chk("R9", "status after write 0", int'(reg_rdata[0]), 1);
        wr(3'd4, 32'd1);
        reg_addr = 3'd4;
        #1 chk("R9", "status after write 1", int'(reg_rdata[0]), 0);
        chk("R9", "irq after clear", int'(irq_o), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule